// File: doc/BRIEF.md
# DMA Bus Ownership and Yield Controller

This block decides when one DMA channel holds the system bus that it shares with a processor core, and when it gives the bus back. A mode input selects how the channel asks for the bus. In snoop style the channel borrows the core's own data path. In grant style it takes the bus through an ordinary request and grant handshake with the arbiter. The block drives one request line. A separate output says which of the two meanings that line currently has. The mode input is captured only while the channel is idle, so a transfer never changes style halfway through.

In grant style, and only when the yield-enable input is set, the core may ask for the bus back while the channel holds it. The block waits for a gap between two engine bus operations, which it sees as engine busy being low. It then drops its request and raises a pause signal toward the engine. When the core withdraws its request, the block asks for the bus again if work is still pending, or goes idle if not. The block moves no data. Its pins are plain control levels, with no valid/ready stream.

Top module: `dma_bus_yield`

## Requirements
- R1: After reset, bus_req, holding, pause and req_is_snoop are all 0, so grant style is selected.
- R2: From idle with work_pending high, bus_req is 1 after the next clock edge and holding stays 0. bus_req stays 1 until bus_grant is seen high at an edge, and holding is 1 after that edge.
- R3: cfg_snoop is captured only in cycles where the channel is idle. A change of cfg_snoop while the channel is requesting or holding the bus leaves req_is_snoop unchanged.
- R4: req_is_snoop shows the captured mode: 1 means bus_req is a snoop-style request, 0 means it is a grant-style request. snoop_path_en is 1 only while req_is_snoop is 1 and bus_req is 1.
- R5: In grant style with yield_en 1, while the block holds the bus and core_yield_req is 1, the block keeps the bus for as long as eng_busy is 1. At the first edge where eng_busy is 0, it releases the bus: after that edge bus_req is 0, holding is 0 and pause is 1.
- R6: With yield_en 0, core_yield_req has no effect. The block keeps holding the bus with bus_req at 1 and pause at 0.
- R7: In snoop style, core_yield_req has no effect whatever the value of yield_en.
- R8: After a release, pause stays 1 for as long as core_yield_req is 1. After the first edge where core_yield_req is 0, pause is 0. bus_req is then 1 if work_pending is 1, and 0 (idle) if it is not.
- R9: While holding, an edge with work_pending 0 and eng_busy 0 returns the block to idle, with bus_req 0 and pause 0. Completion takes priority over a yield request raised in the same cycle.
- R10: pause and bus_req are never 1 together, and holding implies bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_snoop | input | 1 | Request style: 1 snoop, 0 grant |
| yield_en | input | 1 | Allow yielding to the core (grant style only) |
| work_pending | input | 1 | The channel still has transfers to do |
| bus_grant | input | 1 | Arbiter grant or snoop acknowledge |
| core_yield_req | input | 1 | Core asks for the bus back |
| eng_busy | input | 1 | Engine is inside a bus operation |
| bus_req | output | 1 | Bus request, meaning set by req_is_snoop |
| req_is_snoop | output | 1 | Captured request style |
| snoop_path_en | output | 1 | Snoop data path active |
| holding | output | 1 | The channel owns the bus |
| pause | output | 1 | Engine must stall, bus yielded |

## Verification
Two functions can fall in the same cycle. One is normal completion: the block is holding, work_pending is low and eng_busy is low. The other is a permitted yield: grant style, yield_en set and core_yield_req high. The bench sets all of these inputs together in one cycle and checks that the block goes idle with no pause. A second coincidence is a yield request that arrives while eng_busy is still high. The bench checks that the bus is held through the busy cycle and released on the first idle gap.

// File: rtl/dby_pkg.sv
package dby_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_HOLD  = 2'd2,
    ST_YIELD = 2'd3
  } own_state_t;

  localparam logic RESET_MODE_SNOOP = 1'b0;
endpackage

// File: rtl/dby_mode_latch.sv
module dby_mode_latch
  import dby_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_idle,
  input  logic cfg_snoop,
  output logic mode_snoop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_snoop <= RESET_MODE_SNOOP;
    else if (chan_idle) mode_snoop <= cfg_snoop;
  end

  // R3
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_idle |=> $stable(mode_snoop));
endmodule

// File: rtl/dby_yield_gate.sv
module dby_yield_gate (
  input  logic mode_snoop,
  input  logic yield_en,
  input  logic core_yield_req,
  input  logic eng_busy,
  input  logic owning,
  output logic take_yield
);
  logic grant_style;
  always_comb begin
    grant_style = !mode_snoop;
    take_yield  = owning && grant_style && yield_en && core_yield_req && !eng_busy;
  end
endmodule

// File: rtl/dby_own_fsm.sv
module dby_own_fsm
  import dby_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       work_pending,
  input  logic       bus_grant,
  input  logic       eng_busy,
  input  logic       core_yield_req,
  input  logic       take_yield,
  output own_state_t state,
  output logic       chan_idle,
  output logic       owning
);
  own_state_t nxt;
  logic done_now;

  always_comb begin
    done_now = !work_pending && !eng_busy;
    nxt = state;
    unique case (state)
      ST_IDLE:  if (work_pending) nxt = ST_REQ;
      ST_REQ:   if (bus_grant) nxt = ST_HOLD;
      ST_HOLD: begin
        if (done_now)        nxt = ST_IDLE;
        else if (take_yield) nxt = ST_YIELD;
      end
      ST_YIELD: if (!core_yield_req) nxt = work_pending ? ST_REQ : ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    chan_idle = (state == ST_IDLE);
    owning    = (state == ST_HOLD);
  end

  // R5
  yield_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owning && take_yield && (work_pending || eng_busy)) |=> (state == ST_YIELD));
  // R6
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owning && !take_yield && (work_pending || eng_busy)) |=> owning);
  // R8
  yield_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_YIELD && core_yield_req) |=> (state == ST_YIELD));
  // R9
  finish_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owning && !work_pending && !eng_busy) |=> chan_idle);
endmodule

// File: rtl/dma_bus_yield.sv
module dma_bus_yield
  import dby_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_snoop,
  input  logic yield_en,
  input  logic work_pending,
  input  logic bus_grant,
  input  logic core_yield_req,
  input  logic eng_busy,
  output logic bus_req,
  output logic req_is_snoop,
  output logic snoop_path_en,
  output logic holding,
  output logic pause
);
  own_state_t state;
  logic chan_idle, owning, mode_snoop, take_yield;

  dby_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .chan_idle(chan_idle),
    .cfg_snoop(cfg_snoop), .mode_snoop(mode_snoop)
  );

  dby_yield_gate u_gate (
    .mode_snoop(mode_snoop), .yield_en(yield_en), .core_yield_req(core_yield_req),
    .eng_busy(eng_busy), .owning(owning), .take_yield(take_yield)
  );

  dby_own_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .work_pending(work_pending), .bus_grant(bus_grant),
    .eng_busy(eng_busy), .core_yield_req(core_yield_req), .take_yield(take_yield),
    .state(state), .chan_idle(chan_idle), .owning(owning)
  );

  always_comb begin
    bus_req       = (state == ST_REQ) || (state == ST_HOLD);
    holding       = owning;
    pause         = (state == ST_YIELD);
    req_is_snoop  = mode_snoop;
    snoop_path_en = mode_snoop && bus_req;
  end

  // R10
  pause_req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pause && bus_req));
  // R10
  hold_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holding |-> bus_req);
  // R7
  snoop_no_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && req_is_snoop) |=> !pause);
endmodule

// File: tb/sim_dma_bus_yield.sv
module sim_dma_bus_yield;
  logic clk = 0, rst_n = 0;
  logic cfg_snoop = 0, yield_en = 0, work_pending = 0, bus_grant = 0;
  logic core_yield_req = 0, eng_busy = 0;
  logic bus_req, req_is_snoop, snoop_path_en, holding, pause;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  dma_bus_yield u0 (
    .clk(clk), .rst_n(rst_n), .cfg_snoop(cfg_snoop), .yield_en(yield_en),
    .work_pending(work_pending), .bus_grant(bus_grant), .core_yield_req(core_yield_req),
    .eng_busy(eng_busy), .bus_req(bus_req), .req_is_snoop(req_is_snoop),
    .snoop_path_en(snoop_path_en), .holding(holding), .pause(pause)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_idle();
    work_pending = 0; eng_busy = 0; core_yield_req = 0; tick(2);
  endtask

  task automatic t_reset();
    chk("R1", "bus_req", bus_req, 0);
    chk("R1", "holding", holding, 0);
    chk("R1", "pause", pause, 0);
    chk("R1", "req_is_snoop", req_is_snoop, 0);
  endtask

  task automatic t_grant_flow();
    bus_grant = 0; work_pending = 1; eng_busy = 1; tick();
    chk("R2", "bus_req after pending", bus_req, 1);
    chk("R2", "holding before grant", holding, 0);
    tick(2);
    chk("R2", "bus_req waiting grant", bus_req, 1);
    chk("R4", "grant style", req_is_snoop, 0);
    chk("R4", "snoop path off", snoop_path_en, 0);
    bus_grant = 1; tick();
    chk("R2", "holding after grant", holding, 1);
  endtask

  task automatic t_yield();
    yield_en = 1; core_yield_req = 1; eng_busy = 1; tick();
    chk("R5", "kept while busy", holding, 1);
    eng_busy = 0; tick();
    chk("R5", "pause after gap", pause, 1);
    chk("R5", "bus_req dropped", bus_req, 0);
    chk("R10", "pause/req exclusive", pause & bus_req, 0);
    tick(2);
    chk("R8", "pause held", pause, 1);
    core_yield_req = 0; tick();
    chk("R8", "pause cleared", pause, 0);
    chk("R8", "re-request", bus_req, 1);
    chk("R8", "not yet holding", holding, 0);
    tick();
    chk("R2", "holding again", holding, 1);
  endtask

  task automatic t_yield_disabled();
    yield_en = 0; core_yield_req = 1; eng_busy = 0; tick(3);
    chk("R6", "still holding", holding, 1);
    chk("R6", "bus_req kept", bus_req, 1);
    chk("R6", "no pause", pause, 0);
    core_yield_req = 0;
  endtask

  task automatic t_finish_priority();
    yield_en = 1; core_yield_req = 1; work_pending = 0; eng_busy = 0; tick();
    chk("R9", "idle bus_req", bus_req, 0);
    chk("R9", "no pause", pause, 0);
    chk("R9", "not holding", holding, 0);
    core_yield_req = 0; tick();
  endtask

  task automatic t_yield_no_work();
    work_pending = 1; eng_busy = 1; tick(2);
    chk("R2", "holding", holding, 1);
    yield_en = 1; core_yield_req = 1; eng_busy = 0; tick();
    chk("R5", "yielded", pause, 1);
    work_pending = 0; core_yield_req = 0; tick();
    chk("R8", "idle after yield", bus_req, 0);
    chk("R8", "pause off", pause, 0);
  endtask

  task automatic t_snoop();
    cfg_snoop = 1; bus_grant = 0; work_pending = 1; eng_busy = 1; tick();
    chk("R4", "snoop style", req_is_snoop, 1);
    chk("R4", "snoop path on", snoop_path_en, 1);
    cfg_snoop = 0; tick();
    chk("R3", "mode frozen", req_is_snoop, 1);
    bus_grant = 1; tick();
    chk("R2", "holding snoop", holding, 1);
    yield_en = 1; core_yield_req = 1; eng_busy = 0; tick(3);
    chk("R7", "no pause in snoop", pause, 0);
    chk("R7", "still holding", holding, 1);
    chk("R3", "mode still frozen", req_is_snoop, 1);
    go_idle();
    chk("R3", "mode recaptured idle", req_is_snoop, 0);
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_grant_flow();
    t_yield();
    t_yield_disabled();
    t_finish_priority();
    t_yield_no_work();
    t_snoop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule